// File: doc/BRIEF.md
# Raster Position and Sync Status Generator

This block is the timing core of a video display controller. It runs on the dot clock and keeps three pieces of state: the dot position inside the current line, the line number inside the current field, and an odd/even field flag. The dot and line counters wrap at limits taken from a programmable total register. When interlaced output is selected, the field flag flips each time the line counter wraps.

From that state the block builds a read-only status word. The word gives the current line, the field, a display-active flag and the levels of the horizontal and vertical sync. Lines fall into two kinds: a line whose parity matches the field flag, and any other line. The word is decoded differently for each kind. On the matching kind, the early part of the line, up to the front-porch point, counts as inactive. On the other kind, the last part of the line, from the back-porch point on, counts as inactive. A simple write port loads four registers: the total size, the sync timing, the front-porch position and the mode configuration.

Top module: `raster_sync_gen`

## Requirements
- R1: After a synchronous active-low reset, the dot position, the line and the field flag are zero. Line size is 864 dots and field size is 625 lines (total reset value 0x0270035F). Vertical sync length is 5 lines and sync width is 128 dots (sync-timing reset value 0x07D6A53F). Front-porch value is 0 and interlace is off.
- R2: Each dot clock advances the dot position. After the last dot (total bits [9:0]), the position returns to 0 and the line advances. After the last line (total bits [25:16]), the line returns to 0.
- R3: A write to the total register (wr_sel 0) keeps only bits [25:16] and [9:0], ignores all other bits, and clears the dot position to 0 on the same edge.
- R4: In interlaced mode (bit 4 of the mode register, wr_sel 3), the field flag inverts each time the line counter wraps to 0. With interlace off, the flag never changes.
- R5: Status bits [9:0] hold the current line and bit 10 holds the field flag (1 = odd).
- R6: On a line whose bit 0 equals the field flag, bit 12 (horizontal sync inactive) is set only when the dot position is greater than 2*(sync-timing bits [6:0] + 1).
- R7: On such a line, bit 13 (vertical sync inactive) is set when the line is at least sync-timing bits [11:8]. Bit 11 (display active) is also set when, in addition, the dot position is greater than the horizontal-position register (wr_sel 2) bits [9:0] plus 1.
- R8: On any other line, bit 12 is always set. Bit 13 is set when the line is at least the vertical sync length. Bit 11 is set when, in addition, the dot position is below the line length minus a fixed back porch of BACK_PORCH_NS, converted to dots.
- R9: While total bits [9:0] are zero, the dot position and the line hold their values.
- R10: If a total-register write lands on the last dot of the last line, the write wins. The position clears, the line is not wrapped and the field does not flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 total, 1 sync timing, 2 front-porch position, 3 mode |
| wr_data | input | 32 | Register write data |
| sync_status | output | 14 | Line, field, active, sync-inactive status word |

## Verification
A write to the total register and the end-of-field wrap can fall on the same clock edge. The bench steps a reference model until it stands on the last dot of the last line, then drives the total write during exactly that cycle. It then compares the status word on every following cycle. The line number must stay on the last line and the field bit must keep its value until the next natural wrap. Only at that later wrap does the flip occur.

// File: rtl/raster_pkg.sv
// Shared widths, register selects and the total-size layout for the
// raster timing block. Assumes 10-bit line and dot fields.
package raster_pkg;
    localparam int PIX_W  = 10;
    localparam int LINE_W = 10;
    localparam int STS_W  = 14;

    typedef enum logic [1:0] {
        SEL_TOTAL    = 2'd0,
        SEL_SYNCTIME = 2'd1,
        SEL_HSTART   = 2'd2,
        SEL_MODE     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LINE_W-1:0] last_line;
        logic [PIX_W-1:0]  last_dot;
    } total_t;
endpackage

// File: rtl/raster_regs.sv
// Register file for the raster timing block. It stores only the fields
// the counters and decoder use. It also issues a one-cycle strobe when
// the total register is written. Assumes writes are single-cycle strobes.
module raster_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output total_t            total,
    output logic [3:0]        vs_len,
    output logic [6:0]        hs_raw,
    output logic [PIX_W-1:0]  fp_raw,
    output logic              interlace,
    output logic              tot_wr
);
    logic unused_wdata;
    assign unused_wdata = ^{wr_data[31:26], wr_data[15:12], wr_data[7]};

    // Decode the total-register strobe for the counters.
    assign tot_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_TOTAL);

    // Load the selected register fields, or the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total.last_line <= 10'h270;
            total.last_dot  <= 10'h35F;
            vs_len          <= 4'h5;
            hs_raw          <= 7'h3F;
            fp_raw          <= '0;
            interlace       <= 1'b0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_TOTAL: begin
                    total.last_line <= wr_data[25:16];
                    total.last_dot  <= wr_data[9:0];
                end
                SEL_SYNCTIME: begin
                    vs_len <= wr_data[11:8];
                    hs_raw <= wr_data[6:0];
                end
                SEL_HSTART: fp_raw    <= wr_data[9:0];
                default:    interlace <= wr_data[4];
            endcase
        end
    end
endmodule

// File: rtl/raster_counter.sv
// Dot, line and field counters. A total write clears the dot position
// and takes priority over the wrap. A zero line size freezes counting.
module raster_counter
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  total_t            total,
    input  logic              interlace,
    input  logic              tot_wr,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              field
);
    logic dot_end;
    logic field_end;

    assign dot_end   = (pix >= total.last_dot);
    assign field_end = (line >= total.last_line);

    // Advance the raster position and flip the field on interlaced wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix   <= '0;
            line  <= '0;
            field <= 1'b0;
        end else if (tot_wr) begin
            pix <= '0;
        end else if (total.last_dot != '0) begin
            if (dot_end) begin
                pix <= '0;
                if (field_end) begin
                    line <= '0;
                    if (interlace) field <= ~field;
                end else begin
                    line <= line + 1'b1;
                end
            end else begin
                pix <= pix + 1'b1;
            end
        end
    end

    a_r2_pix_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pix <= total.last_dot) || (total.last_dot == '0));

    a_r2_line_moves_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line) |-> (pix == '0));

    a_r3_write_clears_pix: assert property (@(posedge clk) disable iff (!rst_n)
        tot_wr |=> (pix == '0));

    a_r4_field_stable_progressive: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace |=> $stable(field));

    a_r9_hold_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (total.last_dot == '0 && !tot_wr) |=> ($stable(pix) && $stable(line)));

    a_r10_write_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tot_wr |=> ($stable(line) && $stable(field)));
endmodule

// File: rtl/raster_status.sv
// Builds the sync status word from the raster position. Lines whose
// parity matches the field flag use the sync-width and front-porch
// rules. Other lines use the back-porch rule. BP_DOTS is the back porch
// length in dots.
module raster_status
    import raster_pkg::*;
#(
    parameter int BP_DOTS = 108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic              field,
    input  logic [PIX_W-1:0]  last_dot,
    input  logic [3:0]        vs_len,
    input  logic [6:0]        hs_raw,
    input  logic [PIX_W-1:0]  fp_raw,
    output logic [STS_W-1:0]  sts
);
    int hs_w, fp_end, line_dots, bp_start, pix_i;
    logic same_kind, past_vs, hs_off, active;

    // Derive the dot thresholds from the register fields.
    always_comb begin
        pix_i     = int'(pix);
        hs_w      = 2 * (int'(hs_raw) + 1);
        fp_end    = int'(fp_raw) + 1;
        line_dots = int'(last_dot) + 1;
        bp_start  = line_dots - BP_DOTS;
    end

    // Decode the sync and active flags for the two kinds of line.
    always_comb begin
        same_kind = (line[0] == field);
        past_vs   = (line >= {{(LINE_W-4){1'b0}}, vs_len});
        if (same_kind) begin
            hs_off = (pix_i > hs_w);
            active = past_vs && (pix_i > fp_end);
        end else begin
            hs_off = 1'b1;
            active = past_vs && (pix_i < bp_start);
        end
        sts = {past_vs, hs_off, active, field, line};
    end

    a_r7_active_needs_vsync_off: assert property (@(posedge clk) disable iff (!rst_n)
        sts[11] |-> sts[13]);

    a_r6_hsync_early_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (line[0] == field && pix_i <= hs_w) |-> !sts[12]);

    a_r8_other_line_hsync_off: assert property (@(posedge clk) disable iff (!rst_n)
        (line[0] != field) |-> sts[12]);
endmodule

// File: rtl/raster_sync_gen.sv
// Top of the raster timing block: register file, position counters and
// status decoder. Runs on the dot clock. The back porch is fixed at
// elaboration from BACK_PORCH_NS and DOT_CLOCK_KHZ.
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int BACK_PORCH_NS = 4000,
    parameter int DOT_CLOCK_KHZ = 27000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output logic [STS_W-1:0] sync_status
);
    localparam int BP_DOTS = BACK_PORCH_NS * DOT_CLOCK_KHZ / 1000000;

    total_t            total;
    logic [3:0]        vs_len;
    logic [6:0]        hs_raw;
    logic [PIX_W-1:0]  fp_raw;
    logic              interlace;
    logic              tot_wr;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    logic              field;

    raster_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .total(total), .vs_len(vs_len), .hs_raw(hs_raw),
        .fp_raw(fp_raw), .interlace(interlace), .tot_wr(tot_wr)
    );

    raster_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .total(total), .interlace(interlace),
        .tot_wr(tot_wr), .pix(pix), .line(line), .field(field)
    );

    raster_status #(.BP_DOTS(BP_DOTS)) u_sts (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line(line), .field(field),
        .last_dot(total.last_dot), .vs_len(vs_len), .hs_raw(hs_raw),
        .fp_raw(fp_raw), .sts(sync_status)
    );
endmodule

// File: tb/tb_raster_sync_gen.sv
// Scoreboard bench: the driver pushes expected status words from a
// reference model written from the requirements. The monitor pops each
// one and compares it with the design output.
module tb_raster_sync_gen;
    localparam int BP = 4;   // 4000 ns at 1000 kHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [13:0] sync_status;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    raster_sync_gen #(.BACK_PORCH_NS(4000), .DOT_CLOCK_KHZ(1000)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sync_status(sync_status)
    );

    // Reference model state
    int m_pix, m_line, m_field, m_ld, m_ll, m_vs, m_hs, m_hp, m_il;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pix = 0; m_line = 0; m_field = 0;
            m_ld = 'h35F; m_ll = 'h270; m_vs = 5; m_hs = 'h3F; m_hp = 0; m_il = 0;
        end else begin
            if (wr_en && wr_sel == 2'd0) m_pix = 0;
            else if (m_ld != 0) begin
                if (m_pix >= m_ld) begin
                    m_pix = 0;
                    if (m_line >= m_ll) begin
                        m_line = 0;
                        if (m_il != 0) m_field = 1 - m_field;
                    end else m_line = m_line + 1;
                end else m_pix = m_pix + 1;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin m_ll = int'(wr_data[25:16]); m_ld = int'(wr_data[9:0]); end
                    2'd1: begin m_vs = int'(wr_data[11:8]); m_hs = int'(wr_data[6:0]); end
                    2'd2: m_hp = int'(wr_data[9:0]);
                    default: m_il = int'(wr_data[4]);
                endcase
            end
        end
    end

    function automatic int exp_status();
        int s;
        s = m_line | (m_field << 10);
        if ((m_line % 2) == m_field) begin
            if (m_pix > 2 * (m_hs + 1)) s |= (1 << 12);
            if (m_line >= m_vs) begin
                s |= (1 << 13);
                if (m_pix > m_hp + 1) s |= (1 << 11);
            end
        end else begin
            s |= (1 << 12);
            if (m_line >= m_vs) begin
                s |= (1 << 13);
                if (m_pix < m_ld + 1 - BP) s |= (1 << 11);
            end
        end
        return s;
    endfunction

    typedef struct { int exp; string tag; } item_t;
    item_t sb[$];

    task automatic push_exp(input string tag);
        item_t it;
        it.exp = exp_status();
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Entered just after a negedge; leaves just after a later negedge.
    task automatic run_cycles(input int n, input string tag);
        repeat (n) begin
            push_exp(tag);
            @(negedge clk);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        push_exp(tag);
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each expected item with the design output.
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (int'(sync_status) != it.exp) begin
                n_fail++;
                $display("FAIL %s: status actual=0x%04h expected=0x%04h",
                         it.tag, sync_status, it.exp[13:0]);
            end
        end
    end

    // Driver
    initial begin
        @(negedge clk);
        @(negedge clk);
        run_cycles(2, "R1");                 // during reset
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        run_cycles(1, "R1");                 // reset state: status zero
        run_cycles(900, "R1_R2_R6");         // default totals, line 0 to 1
        // Small raster: 12 lines of 24 dots
        write_reg(2'd1, 32'h0000_0302, "R6");  // vsync 3 lines, sync width 6
        write_reg(2'd2, 32'h0000_0009, "R7");  // front porch ends at dot 10
        write_reg(2'd0, 32'h000B_0017, "R3");
        run_cycles(24 * 12 * 2 + 7, "R2_R5_R7_R8");
        // Interlace on
        write_reg(2'd3, 32'h0000_0010, "R4");
        run_cycles(24 * 12 * 3, "R4_R5");
        // Collision: total write on the last dot of the last line
        while (!(m_pix == 23 && m_line == 11)) run_cycles(1, "R4");
        write_reg(2'd0, 32'h000B_0017, "R10");
        run_cycles(24 * 12 + 30, "R10");
        // Zero line size holds counters
        run_cycles(37, "R2");
        write_reg(2'd0, 32'h0005_0000, "R9");
        run_cycles(60, "R9");
        write_reg(2'd0, 32'h000B_0017, "R9");
        run_cycles(50, "R9");
        // Masked total write with junk bits
        write_reg(2'd0, 32'hFC07_FC0F, "R3");
        run_cycles(16 * 8 * 3, "R3");
        // Interlace off again: field frozen
        write_reg(2'd3, 32'h0000_0000, "R4");
        run_cycles(16 * 8 * 2, "R4");
        @(negedge clk);
        #5;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule